// File: doc/BRIEF.md
# Spare-Stage Bypass Pipeline with Self-Test

The block is a linear datapath of N identical registered stages plus one extra spare stage. At every stage there is a 2:1 selector that either applies the stage function or passes the incoming word through unchanged. Exactly one physical stage is skipped at all times, so the computation always passes through N working stages. Out of reset the spare, which is the last stage, is the one skipped. A built-in sequencer finds a defective stage and moves the bypass onto it. It does this by trying one bypass position after another, pushing a fixed test word through the pipeline and comparing the result with the known answer.

A second sequence, margin tuning, lowers an operating-margin code one step at a time. It re-runs the self-test after each step. If a failure appears that a single bypass can absorb, tuning goes on with that bypass. If no single bypass fixes it, the code goes back up one step and the last working bypass is put back. In silicon the margin code would set a bias current; here it is only a register output. The testbench models stage defects through a stuck-fault input.

Top module: `spb_top`

## Requirements
- R1: With no fault in the active stages, a word accepted on `in_valid`/`in_data` appears on `out_data` with `out_valid` exactly N+1 clock cycles later. The value is g applied N times, where g(x) = rotate-left(x, 5) + 0x9E3779B9 (modulo 2^32).
- R2: After reset, `byp_idx` is N (the spare), `margin` is all ones (15), `busy` and `fatal` are 0 and `out_valid` is 0. `byp_idx` never exceeds N, and exactly one stage is bypassed at all times.
- R3: A pulse on `st_start` runs the self-test. It first tries bypass N, then indices 0 to N-1 in ascending order, and keeps the first index whose result equals g^N(0x0F1E2D3C). A stage whose `flt_stuck` bit is 1 and which is not bypassed outputs the all-zero word.
- R4: If no single bypass index passes, the self-test sets `fatal` and `byp_idx` returns to N. The next start clears `fatal`.
- R5: `byp_idx` changes only at a clock edge where the pipeline holds no valid word.
- R6: While `busy` is 1, `in_valid` is ignored and `out_valid` stays 0. No word offered during that time ever reaches the output.
- R7: A pulse on `tune_start` lowers `margin` by one step at a time and re-runs the self-test at each step. The sequence ends at margin 0, or at the first step where no single bypass passes. In that case `margin` goes back up by one and `byp_idx` returns to the bypass that last passed, with `fatal` left at 0.
- R8: `margin` changes by exactly one step at a time, never changes while idle without `tune_start`, and `tune_start` at margin 0 changes nothing.
- R9: After a self-test has moved the bypass onto a faulty stage, words pass through with the R1 value even though that fault is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| st_start | input | 1 | Start self-test (one-cycle pulse while idle) |
| tune_start | input | 1 | Start margin tuning (one-cycle pulse while idle) |
| flt_stuck | input | N+1 | Per-stage defect model: the stage's computed result is stuck at zero |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| busy | output | 1 | Self-test or tuning in progress |
| fatal | output | 1 | Last self-test found no working bypass |
| byp_idx | output | $clog2(N+1) | Index of the stage currently bypassed |
| margin | output | 4 | Operating-margin code |

## Verification
The bench injects a fault into each stage in turn, including the spare. A sequencer with the wrong search order, or one that kept the default bypass after a failure, would report the wrong index, and the data checked afterwards would come out wrong. Every pair of two faults is applied. A design that quietly settled on a partly working bypass would then leave `fatal` low. Margin tuning runs against threshold-driven fault models. These cover a stage that fails alone, a second stage that fails below it, and a spare that fails alongside an already-bypassed stage. An off-by-one in the restore step would leave the margin one step too low or lose the saved bypass. Words offered while the sequencer is busy must never appear at the output.

// File: rtl/spb_pkg.sv
// Shared definitions for the spare-stage bypass pipeline.
// Assumes a 32-bit datapath; the stage function is a placeholder mixer.
package spb_pkg;

    localparam int DW = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DRAIN,
        S_PUSH,
        S_WAIT,
        S_FIN
    } ctl_st_e;

    // One stage of work: rotate left by five, then add the round key.
    function automatic logic [DW-1:0] stage_fn(input logic [DW-1:0] x,
                                               input logic [DW-1:0] k);
        return {x[DW-6:0], x[DW-1:DW-5]} + k;
    endfunction

    // The stage function applied n times (used for the self-test golden value).
    function automatic logic [DW-1:0] stage_chain(input logic [DW-1:0] x,
                                                  input logic [DW-1:0] k,
                                                  input int n);
        logic [DW-1:0] v;
        v = x;
        for (int i = 0; i < n; i++) v = stage_fn(v, k);
        return v;
    endfunction

endpackage

// File: rtl/spb_stage.sv
// One pipeline stage with its bypass selector.
// When byp_sel is set, the input word is registered unchanged. Otherwise the
// stage function result is registered. stuck models a defect in the compute
// logic that forces its result to zero; the bypass path is assumed sound.
module spb_stage
    import spb_pkg::*;
#(
    parameter logic [DW-1:0] KEY = 32'h9E3779B9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          d_vld,
    input  logic [DW-1:0] d_dat,
    input  logic          byp_sel,
    input  logic          stuck,
    output logic          q_vld,
    output logic [DW-1:0] q_dat
);

    logic [DW-1:0] calc;

    // Compute path, including the injected defect.
    always_comb calc = stuck ? '0 : stage_fn(d_dat, KEY);

    // Stage register: valid flag and bypass-selected data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q_dat <= '0;
        end else begin
            q_vld <= d_vld;
            q_dat <= byp_sel ? d_dat : calc;
        end
    end

endmodule

// File: rtl/spb_pipe.sv
// Chain of N_STG+1 stages, one of which is bypassed according to byp_idx.
// Assumes byp_idx <= N_STG. Reports when no valid word is in flight.
module spb_pipe
    import spb_pkg::*;
#(
    parameter int            N_STG = 4,
    parameter logic [DW-1:0] KEY   = 32'h9E3779B9,
    localparam int           NS    = N_STG + 1,
    localparam int           IW    = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_dat,
    input  logic [IW-1:0] byp_idx,
    input  logic [NS-1:0] stuck,
    output logic          out_vld,
    output logic [DW-1:0] out_dat,
    output logic          empty
);

    logic [NS:0]   vc;
    logic [DW-1:0] dc [NS+1];
    logic [NS-1:0] bsel;

    assign vc[0] = in_vld;
    assign dc[0] = in_dat;

    for (genvar g = 0; g < NS; g++) begin : g_stg
        assign bsel[g] = (byp_idx == IW'(g));
        spb_stage #(.KEY(KEY)) u_stg (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_vld  (vc[g]),
            .d_dat  (dc[g]),
            .byp_sel(bsel[g]),
            .stuck  (stuck[g]),
            .q_vld  (vc[g+1]),
            .q_dat  (dc[g+1])
        );
    end

    assign out_vld = vc[NS];
    assign out_dat = dc[NS];
    assign empty   = ~|vc[NS:1];

    AST_ONE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bsel) == 1); // R2

endmodule

// File: rtl/spb_ctl.sv
// Self-test and margin-tuning sequencer.
// Self-test: drain the pipeline, try the spare bypass, then indices 0..N-1,
// pushing TEST_IN and comparing with its known image. Tuning repeats the
// self-test at each lower margin step and backs off one step when no single
// bypass works. Assumes st_start/tune_start are only pulsed while idle.
module spb_ctl
    import spb_pkg::*;
#(
    parameter int            N_STG   = 4,
    parameter int            MW      = 4,
    parameter logic [DW-1:0] KEY     = 32'h9E3779B9,
    parameter logic [DW-1:0] TEST_IN = 32'h0F1E2D3C,
    localparam int           NS      = N_STG + 1,
    localparam int           IW      = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_start,
    input  logic          tune_start,
    input  logic          p_out_vld,
    input  logic [DW-1:0] p_out_dat,
    input  logic          p_empty,
    output logic          busy,
    output logic          tst_push,
    output logic [IW-1:0] byp_idx,
    output logic          fatal,
    output logic [MW-1:0] margin
);

    localparam logic [IW-1:0] SPARE = IW'(N_STG);
    localparam logic [IW-1:0] LAST  = IW'(N_STG - 1);
    localparam logic [DW-1:0] GOLD  = stage_chain(TEST_IN, KEY, N_STG);

    ctl_st_e       st;
    logic          first;
    logic          tuning;
    logic [IW-1:0] cand;
    logic [IW-1:0] saved;
    logic          pass;

    // Decoded status toward the datapath and the ports.
    assign busy     = (st != S_IDLE);
    assign tst_push = (st == S_PUSH);
    assign pass     = (p_out_dat == GOLD);

    // Sequencer state, bypass choice, margin code and fatal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            first   <= 1'b1;
            tuning  <= 1'b0;
            cand    <= '0;
            saved   <= SPARE;
            byp_idx <= SPARE;
            fatal   <= 1'b0;
            margin  <= '1;
        end else begin
            case (st)
                S_IDLE: begin
                    if (st_start) begin
                        fatal  <= 1'b0;
                        tuning <= 1'b0;
                        first  <= 1'b1;
                        st     <= S_DRAIN;
                    end else if (tune_start && margin != '0) begin
                        fatal  <= 1'b0;
                        margin <= margin - 1'b1;
                        saved  <= byp_idx;
                        tuning <= 1'b1;
                        first  <= 1'b1;
                        st     <= S_DRAIN;
                    end
                end
                S_DRAIN: begin
                    if (p_empty) begin
                        byp_idx <= first ? SPARE : cand;
                        st      <= S_PUSH;
                    end
                end
                S_PUSH: st <= S_WAIT;
                S_WAIT: begin
                    if (p_out_vld) begin
                        if (pass) begin
                            if (tuning && margin != '0) begin
                                margin <= margin - 1'b1;
                                saved  <= byp_idx;
                                first  <= 1'b1;
                                st     <= S_DRAIN;
                            end else begin
                                tuning <= 1'b0;
                                st     <= S_IDLE;
                            end
                        end else if (first) begin
                            first <= 1'b0;
                            cand  <= '0;
                            st    <= S_DRAIN;
                        end else if (cand == LAST) begin
                            st <= S_FIN;
                        end else begin
                            cand <= cand + 1'b1;
                            st   <= S_DRAIN;
                        end
                    end
                end
                S_FIN: begin
                    byp_idx <= tuning ? saved : SPARE;
                    fatal   <= ~tuning;
                    if (tuning) margin <= margin + 1'b1;
                    tuning  <= 1'b0;
                    st      <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_BYP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        byp_idx <= SPARE); // R2

    AST_FATAL_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> byp_idx == SPARE); // R4

    AST_MARGIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(margin) |-> (margin == MW'($past(margin) + 1'b1)) ||
                             (margin == MW'($past(margin) - 1'b1))); // R8

    AST_MARGIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tune_start) |=> $stable(margin)); // R8

    AST_ZERO_TUNE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !st_start && tune_start && margin == '0) |=> !busy); // R8

endmodule

// File: rtl/spb_top.sv
// Spare-stage bypass pipeline: N working stages plus one spare, a bypass
// selector per stage, and a self-test / margin-tuning sequencer. While the
// sequencer is busy, the external input is blocked and the output is masked.
module spb_top
    import spb_pkg::*;
#(
    parameter int            N_STG   = 4,
    parameter int            MW      = 4,
    parameter logic [DW-1:0] KEY     = 32'h9E3779B9,
    parameter logic [DW-1:0] TEST_IN = 32'h0F1E2D3C,
    localparam int           NS      = N_STG + 1,
    localparam int           IW      = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          st_start,
    input  logic          tune_start,
    input  logic [NS-1:0] flt_stuck,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          busy,
    output logic          fatal,
    output logic [IW-1:0] byp_idx,
    output logic [MW-1:0] margin
);

    logic          tst_push;
    logic          p_in_vld;
    logic [DW-1:0] p_in_dat;
    logic          p_out_vld;
    logic [DW-1:0] p_out_dat;
    logic          p_empty;

    // Input steering: the sequencer owns the pipeline while busy.
    always_comb begin
        p_in_vld = busy ? tst_push : in_valid;
        p_in_dat = busy ? TEST_IN  : in_data;
    end

    spb_pipe #(.N_STG(N_STG), .KEY(KEY)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (p_in_vld),
        .in_dat (p_in_dat),
        .byp_idx(byp_idx),
        .stuck  (flt_stuck),
        .out_vld(p_out_vld),
        .out_dat(p_out_dat),
        .empty  (p_empty)
    );

    spb_ctl #(.N_STG(N_STG), .MW(MW), .KEY(KEY), .TEST_IN(TEST_IN)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_start  (st_start),
        .tune_start(tune_start),
        .p_out_vld (p_out_vld),
        .p_out_dat (p_out_dat),
        .p_empty   (p_empty),
        .busy      (busy),
        .tst_push  (tst_push),
        .byp_idx   (byp_idx),
        .fatal     (fatal),
        .margin    (margin)
    );

    // Output masking: test words never leave the block.
    assign out_valid = p_out_vld & ~busy;
    assign out_data  = p_out_dat;

    AST_SEL_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byp_idx) |-> $past(p_empty)); // R5

    AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !out_valid); // R6

endmodule

// File: tb/sim_spb_top.sv
// Self-checking bench for spb_top with N_STG = 4 (five physical stages).
module sim_spb_top;

    localparam int          NB  = 4;
    localparam int          NS  = NB + 1;
    localparam logic [31:0] K   = 32'h9E3779B9;
    localparam logic [31:0] TIN = 32'h0F1E2D3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        st_start = 1'b0;
    logic        tune_start = 1'b0;
    logic [NS-1:0] flt_stuck;
    logic        out_valid;
    logic [31:0] out_data;
    logic        busy;
    logic        fatal;
    logic [2:0]  byp_idx;
    logic [3:0]  margin;

    logic [NS-1:0] stat_flt = '0;
    logic [3:0]    thr [NS];
    logic [31:0]   exp_q [$];
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;
    int            busy_outs = 0;

    always #5 clk = ~clk;

    spb_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .st_start(st_start), .tune_start(tune_start), .flt_stuck(flt_stuck),
        .out_valid(out_valid), .out_data(out_data), .busy(busy),
        .fatal(fatal), .byp_idx(byp_idx), .margin(margin)
    );

    // Defect model: static faults plus margin-dependent weak stages.
    always_comb begin
        for (int i = 0; i < NS; i++)
            flt_stuck[i] = stat_flt[i] | (margin < thr[i]);
    end

    function automatic logic [31:0] ref_g(input logic [31:0] x);
        return {x[26:0], x[31:27]} + K;
    endfunction

    function automatic logic [31:0] ref_chain(input logic [31:0] x);
        logic [31:0] v;
        v = x;
        for (int i = 0; i < NB; i++) v = ref_g(v);
        return v;
    endfunction

    // Expected self-test outcome for a set of failing stages.
    task automatic model(input logic [NS-1:0] bad, output int idx, output bit fat);
        int nsp;
        nsp = $countones(bad[NB-1:0]);
        idx = NB;
        fat = 1'b0;
        if (nsp == 1 && !bad[NB]) begin
            for (int i = 0; i < NB; i++) if (bad[i]) idx = i;
        end else if (nsp != 0) begin
            fat = 1'b1;
        end
    endtask

    function automatic logic [NS-1:0] bad_at(input int m);
        logic [NS-1:0] b;
        for (int i = 0; i < NS; i++) b[i] = stat_flt[i] | (m < int'(thr[i]));
        return b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Output monitor: every emitted word must match the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (busy) busy_outs++;
            if (exp_q.size() == 0) begin
                chk("R6 unexpected output", out_data, 32'hxxxxxxxx);
            end else begin
                chk("R1/R9 data", out_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset byp", 32'(byp_idx), NB);
        chk("R2 reset margin", 32'(margin), 15);
        chk("R2 reset busy/fatal/out", {29'd0, busy, fatal, out_valid}, 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_st();
        st_start = 1'b1;
        @(negedge clk);
        st_start = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic stream(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = seed ^ (32'(i) * 32'h01234567);
            exp_q.push_back(ref_chain(in_data));
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (NS + 2) @(negedge clk);
        chk("R1 all words emitted", 32'(exp_q.size()), 0);
    endtask

    task automatic tune_case(input string tag);
        int m, bp, idx;
        bit fat;
        m = int'(margin);
        bp = int'(byp_idx);
        while (m > 0) begin
            model(bad_at(m - 1), idx, fat);
            if (fat) break;
            m--;
            bp = idx;
        end
        tune_start = 1'b1;
        @(negedge clk);
        tune_start = 1'b0;
        @(negedge clk);
        wait_idle();
        chk({"R7 margin ", tag}, 32'(margin), 32'(m));
        chk({"R7 byp ", tag}, 32'(byp_idx), 32'(bp));
        chk({"R7 fatal ", tag}, 32'(fatal), 0);
    endtask

    initial begin
        int idx, lat;
        bit fat;
        for (int i = 0; i < NS; i++) thr[i] = 4'd0;
        do_reset();

        // R1: latency of a single word, then a back-to-back stream.
        in_valid = 1'b1;
        in_data  = 32'hCAFE0001;
        exp_q.push_back(ref_chain(in_data));
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R1 latency", 32'(lat), NS);
        repeat (2) @(negedge clk);
        stream(20, 32'h5A5A0000);

        // R3: clean self-test keeps the spare bypassed.
        pulse_st();
        chk("R3 clean byp", 32'(byp_idx), NB);
        chk("R3 clean fatal", 32'(fatal), 0);

        // R3/R9: single fault in every stage, including the spare.
        for (int s = 0; s < NS; s++) begin
            stat_flt = NS'(1) << s;
            pulse_st();
            model(stat_flt, idx, fat);
            chk("R3 located stage", 32'(byp_idx), 32'(idx));
            chk("R3 no fatal", 32'(fatal), 0);
            stream(8, 32'(s) * 32'h1111_0000);
        end

        // R4: every pair of faults with one spare.
        for (int a = 0; a < NS; a++) begin
            for (int b = a + 1; b < NS; b++) begin
                stat_flt = (NS'(1) << a) | (NS'(1) << b);
                pulse_st();
                model(stat_flt, idx, fat);
                chk("R4 fatal", 32'(fatal), 32'(fat));
                chk("R4 byp", 32'(byp_idx), 32'(idx));
            end
        end

        // R4: a clean rerun clears fatal.
        stat_flt = '0;
        pulse_st();
        chk("R4 fatal cleared", 32'(fatal), 0);

        // R6: words offered while busy are dropped and nothing is emitted.
        stat_flt = 5'b00100;
        busy_outs = 0;
        st_start = 1'b1;
        @(negedge clk);
        st_start = 1'b0;
        @(negedge clk);
        while (busy) begin
            in_valid = 1'b1;
            in_data  = 32'hDEAD0000 ^ 32'(cyc);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (NS + 2) @(negedge clk);
        chk("R6 outputs during busy", 32'(busy_outs), 0);
        chk("R6 dropped words", 32'(exp_q.size()), 0);
        chk("R3 byp after busy test", 32'(byp_idx), 2);
        stat_flt = '0;

        // R7/R8: margin tuning against weak-stage thresholds.
        do_reset();
        thr[2] = 4'd9;
        thr[0] = 4'd5;
        tune_case("two weak stages");
        stream(6, 32'h7777_0000);

        do_reset();
        for (int i = 0; i < NS; i++) thr[i] = 4'd0;
        tune_case("no weak stage");
        tune_case("at zero R8");

        do_reset();
        thr[NB] = 4'd7;
        tune_case("weak spare only");

        do_reset();
        thr[NB] = 4'd10;
        thr[1]  = 4'd12;
        tune_case("spare fails behind bypass");
        stream(6, 32'h3C3C_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule